// File: doc/BRIEF.md
# Multiphase NCO Clock Generator

This block turns a fast system clock into a slow square-wave clock by repeated addition. A 32-bit phase accumulator grows by a tuning word every system cycle, and its top bit is the generated clock. The output frequency is the system frequency times the tuning word divided by 2^32. A host writes a new tuning word with a one-cycle load strobe. The strobe can come at any time, and the running phase is kept.

To place output edges more finely than one system period, the block adds three fixed fractions of the tuning word (one quarter, one half, three quarters) to the current accumulator value. Only the top bit of each of these sums is used. Together with the next accumulator value, these give four samples of the clock at quarter-cycle spacing. The four samples are presented each cycle as a parallel 4-bit word, ordered earliest to latest. A round-robin slot machine (states SLOT_Q1, SLOT_Q2, SLOT_Q3, SLOT_FULL) also picks one of them per cycle onto a serial output. A downstream double-rate or faster output stage can then use either form.

Because only one accumulator is fed back, the quarter-phase taps cannot drift apart. The three fraction adders use only the top OFS_W bits of their operands, which is enough to tell which quarter of a period an edge falls in.

The slot machine moves SLOT_Q1 → SLOT_Q2 → SLOT_Q3 → SLOT_FULL → SLOT_Q1. It moves once per cycle with no other transitions, and reset forces SLOT_Q1.

Top module: `nco_quad_clkgen`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the accumulator, the stored tuning word and its fractions, the phase word, the serial bit, and the slot (slot code 0). Reset takes priority over a load in the same cycle.
- R2: On each rising edge out of reset the accumulator becomes (accumulator + stored tuning word) mod 2^32. The clk_out output equals bit 31 of the accumulator.
- R3: When tune_load is high at an edge, tune_word is stored at that edge. The next edge is the first accumulator update that uses it. The accumulator is not cleared by a load.
- R4: On a load the block stores three fractions of the new word: q1 = N>>2, q2 = N>>1 and q3 = q1 + q2.
- R5: At each edge out of reset, phase_bits is updated from the accumulator value A before the edge. Bits 0, 1 and 2 are bit OFS_W-1 of the OFS_W-bit sum of the top OFS_W bits of A and of q1, q2 and q3 respectively. Bit 3 is bit 31 of A+N, which equals the new clk_out.
- R6: The slot output steps 0,1,2,3,0,... by one on every edge out of reset. Code 0 is SLOT_Q1, 1 is SLOT_Q2, 2 is SLOT_Q3 and 3 is SLOT_FULL.
- R7: At each edge out of reset, ser_bit takes the tap whose index equals the slot code before that edge. The tap values are the same as those loaded into phase_bits at that edge.
- R8: While tune_load is low, tune_word has no effect on any output.
- R9: With a stored tuning word of zero, clk_out stays constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| tune_load | input | 1 | Store strobe for tune_word |
| tune_word | input | 32 | Tuning word from the host |
| clk_out | output | 1 | Top bit of the accumulator |
| phase_bits | output | 4 | Quarter-phase samples, bit 0 earliest, bit 3 latest |
| ser_bit | output | 1 | Round-robin serialized sample |
| ser_slot | output | 2 | Current slot code of the serializer |

## Verification
The bench targets loads that arrive while reset is high. A design that let the load win would run with a nonzero word straight after reset. It also targets the one-cycle gap between a load and its first use: an early or late hand-over shifts clk_out by a whole step and never recovers. Tuning words close to 2^32 and exact powers of two stress the wrap of the accumulator and the carry lost in the narrow fraction adders. A wrong truncation point or an off-by-one fraction flips phase_bits near quarter boundaries. The bench also changes tune_word with the strobe low, which exposes a missing load qualifier. It checks serial slot alignment every cycle, so a serializer indexing the wrong tap shows up within four cycles.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam int NCO_ACC_W = 32;
    localparam int NCO_OFS_W = 8;
    localparam int NCO_TAPS  = 4;

    typedef enum logic [1:0] {
        SLOT_Q1   = 2'd0,
        SLOT_Q2   = 2'd1,
        SLOT_Q3   = 2'd2,
        SLOT_FULL = 2'd3
    } slot_e;

endpackage

// File: rtl/nco_tune_store.sv
module nco_tune_store #(
    parameter int ACC_W = nco_pkg::NCO_ACC_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [ACC_W-1:0]   word,
    output logic [ACC_W-1:0]   n_q,
    output logic [3*ACC_W-1:0] frac_q
);

    logic [ACC_W-1:0] quarter_w;
    logic [ACC_W-1:0] half_w;
    logic [ACC_W-1:0] three_q_w;

    // fractions by shift, three quarters with one adder
    always_comb begin
        quarter_w = word >> 2;
        half_w    = word >> 1;
        three_q_w = quarter_w + half_w;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            n_q    <= '0;
            frac_q <= '0;
        end else if (load) begin
            n_q    <= word;
            frac_q <= {three_q_w, half_w, quarter_w};
        end
    end

    logic chk_armed;
    always_ff @(posedge clk) begin
        if (rst) chk_armed <= 1'b1;
    end

    // R3
    tune_capture_chk: assert property (@(posedge clk) disable iff (rst || !chk_armed)
        load |=> (n_q == $past(word)));

    // R4
    tune_frac_chk: assert property (@(posedge clk) disable iff (rst || !chk_armed)
        load |=> ((frac_q[ACC_W-1:0] == (n_q >> 2)) &&
                  (frac_q[2*ACC_W-1:ACC_W] == (n_q >> 1))));

    // R8
    tune_hold_chk: assert property (@(posedge clk) disable iff (rst || !chk_armed)
        !load |=> $stable(n_q));

endmodule

// File: rtl/nco_phase_core.sv
module nco_phase_core #(
    parameter int ACC_W = nco_pkg::NCO_ACC_W,
    parameter int OFS_W = nco_pkg::NCO_OFS_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ACC_W-1:0]   n_in,
    input  logic [3*ACC_W-1:0] frac_in,
    output logic               clk_out,
    output logic [3:0]         tap_now,
    output logic [3:0]         phase_q
);

    localparam int TOP = ACC_W - 1;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_nx;

    assign acc_nx = acc_q + n_in;

    // narrow offset adders: only the top OFS_W bits of each operand
    for (genvar k = 0; k < 3; k++) begin : g_off
        logic [OFS_W-1:0] hi_sum;
        assign hi_sum     = acc_q[TOP -: OFS_W] + frac_in[k*ACC_W + TOP -: OFS_W];
        assign tap_now[k] = hi_sum[OFS_W-1];
    end
    assign tap_now[3] = acc_nx[TOP];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            phase_q <= '0;
        end else begin
            acc_q   <= acc_nx;
            phase_q <= tap_now;
        end
    end

    assign clk_out = acc_q[TOP];

    logic chk_armed;
    always_ff @(posedge clk) begin
        if (rst) chk_armed <= 1'b1;
    end

    // R2
    acc_step_chk: assert property (@(posedge clk) disable iff (rst || !chk_armed)
        1'b1 |=> (acc_q == $past(acc_q) + $past(n_in)));

    // R9
    zero_word_chk: assert property (@(posedge clk) disable iff (rst || !chk_armed)
        (n_in == '0) |=> $stable(clk_out));

endmodule

// File: rtl/nco_slot_fsm.sv
module nco_slot_fsm
    import nco_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] tap_now,
    output logic [1:0] slot,
    output logic       ser_bit
);

    slot_e state_q;
    slot_e state_nx;
    logic  pick;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SLOT_Q1;
        else     state_q <= state_nx;
    end

    // transitions: earliest tap to latest, then wrap
    always_comb begin
        unique case (state_q)
            SLOT_Q1:   state_nx = SLOT_Q2;
            SLOT_Q2:   state_nx = SLOT_Q3;
            SLOT_Q3:   state_nx = SLOT_FULL;
            SLOT_FULL: state_nx = SLOT_Q1;
        endcase
    end

    always_comb begin
        unique case (state_q)
            SLOT_Q1:   pick = tap_now[0];
            SLOT_Q2:   pick = tap_now[1];
            SLOT_Q3:   pick = tap_now[2];
            SLOT_FULL: pick = tap_now[3];
        endcase
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) ser_bit <= 1'b0;
        else     ser_bit <= pick;
    end

    assign slot = state_q;

    logic chk_armed;
    always_ff @(posedge clk) begin
        if (rst) chk_armed <= 1'b1;
    end

    // R6
    slot_step_chk: assert property (@(posedge clk) disable iff (rst || !chk_armed)
        1'b1 |=> (slot == 2'($past(slot) + 2'd1)));

endmodule

// File: rtl/nco_quad_clkgen.sv
module nco_quad_clkgen #(
    parameter int ACC_W = nco_pkg::NCO_ACC_W,
    parameter int OFS_W = nco_pkg::NCO_OFS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tune_load,
    input  logic [ACC_W-1:0] tune_word,
    output logic             clk_out,
    output logic [3:0]       phase_bits,
    output logic             ser_bit,
    output logic [1:0]       ser_slot
);

    logic [ACC_W-1:0]   n_q;
    logic [3*ACC_W-1:0] frac_q;
    logic [3:0]         tap_now;

    nco_tune_store #(.ACC_W(ACC_W)) u_tune (
        .clk    (clk),
        .rst    (rst),
        .load   (tune_load),
        .word   (tune_word),
        .n_q    (n_q),
        .frac_q (frac_q)
    );

    nco_phase_core #(.ACC_W(ACC_W), .OFS_W(OFS_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .n_in    (n_q),
        .frac_in (frac_q),
        .clk_out (clk_out),
        .tap_now (tap_now),
        .phase_q (phase_bits)
    );

    nco_slot_fsm u_slot (
        .clk     (clk),
        .rst     (rst),
        .tap_now (tap_now),
        .slot    (ser_slot),
        .ser_bit (ser_bit)
    );

    logic chk_armed;
    always_ff @(posedge clk) begin
        if (rst) chk_armed <= 1'b1;
    end

    // R7
    ser_align_chk: assert property (@(posedge clk) disable iff (rst || !chk_armed)
        ser_bit == phase_bits[2'(ser_slot - 2'd1)]);

endmodule

// File: tb/sim_nco_quad_clkgen.sv
module sim_nco_quad_clkgen;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int OW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tune_load = 1'b0;
    logic [AW-1:0] tune_word = '0;
    logic          clk_out;
    logic [3:0]    phase_bits;
    logic          ser_bit;
    logic [1:0]    ser_slot;

    nco_quad_clkgen #(.ACC_W(AW), .OFS_W(OW)) u0 (
        .clk        (clk),
        .rst        (rst),
        .tune_load  (tune_load),
        .tune_word  (tune_word),
        .clk_out    (clk_out),
        .phase_bits (phase_bits),
        .ser_bit    (ser_bit),
        .ser_slot   (ser_slot)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string tag = "R1";

    // reference state
    logic [AW-1:0] m_acc = '0, m_n = '0, m_q1 = '0, m_q2 = '0, m_q3 = '0;
    logic [3:0]    m_ph = '0;
    logic          m_ser = 1'b0;
    logic [1:0]    m_slot = '0;

    function automatic logic hi_tap(input logic [AW-1:0] a, input logic [AW-1:0] q);
        logic [OW-1:0] s;
        s = a[AW-1 -: OW] + q[AW-1 -: OW];
        return s[OW-1];
    endfunction

    task automatic model_edge();
        logic [3:0] t;
        if (rst) begin
            m_acc = '0; m_n = '0; m_q1 = '0; m_q2 = '0; m_q3 = '0;
            m_ph = '0; m_ser = 1'b0; m_slot = '0;
        end else begin
            t[0] = hi_tap(m_acc, m_q1);
            t[1] = hi_tap(m_acc, m_q2);
            t[2] = hi_tap(m_acc, m_q3);
            t[3] = 1'(((m_acc + m_n) >> (AW-1)) & 1);
            m_ph   = t;
            m_ser  = t[m_slot];
            m_slot = m_slot + 2'd1;
            m_acc  = m_acc + m_n;
            if (tune_load) begin
                m_n  = tune_word;
                m_q1 = tune_word >> 2;
                m_q2 = tune_word >> 1;
                m_q3 = m_q1 + m_q2;
            end
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s [%s] t=%0t actual=%h expected=%h", req, tag, $time, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R2 R3 clk_out", 32'(clk_out), 32'(m_acc[AW-1]));
        chk("R4 R5 phase_bits", 32'(phase_bits), 32'(m_ph));
        chk("R7 ser_bit", 32'(ser_bit), 32'(m_ser));
        chk("R6 ser_slot", 32'(ser_slot), 32'(m_slot));
    endtask

    task automatic load_word(input logic [AW-1:0] w, input int hold);
        tune_word = w;
        tune_load = 1'b1;
        cycle();
        tune_load = 1'b0;
        for (int i = 0; i < hold; i++) cycle();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h0005_EED5);
        @(negedge clk);
        // R1: load during reset must lose
        tag = "R1 reset";
        rst = 1'b1; tune_load = 1'b1; tune_word = 32'h7654_3210;
        for (int i = 0; i < 3; i++) cycle();
        tune_load = 1'b0;
        rst = 1'b0;
        // R9: zero word keeps clk_out still
        tag = "R9 zero";
        for (int i = 0; i < 6; i++) cycle();
        // R8: word changes with strobe low
        tag = "R8 ignore";
        for (int i = 0; i < 5; i++) begin
            tune_word = $urandom;
            cycle();
        end
        // directed corners
        tag = "R3 quarter";
        load_word(32'h4000_0000, 12);
        tag = "R2 half";
        load_word(32'h8000_0000, 8);
        tag = "R2 wrap";
        load_word(32'hFFFF_FFFF, 10);
        tag = "R5 small";
        load_word(32'h0000_1234, 6);
        tag = "R5 odd";
        load_word(32'h2AAA_AAAB, 20);
        tag = "R3 back2back";
        load_word(32'h1000_0001, 0);
        load_word(32'h3333_3333, 0);
        load_word(32'h0F0F_F0F0, 12);
        // random mix
        tag = "R5 R7 random";
        for (int i = 0; i < 3000; i++) begin
            tune_word = $urandom;
            tune_load = ($urandom_range(15) == 0);
            cycle();
        end
        tune_load = 1'b0;
        // reset mid-run
        tag = "R1 midrun";
        rst = 1'b1;
        cycle();
        rst = 1'b0;
        for (int i = 0; i < 4; i++) cycle();
        tag = "R3 after reset";
        load_word(32'h0123_4567, 40);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule